// File: doc/BRIEF.md
# Handshaked Device Reset Sequencer

This block runs the reset of a touch-sensing controller after the command layer has accepted a confirmed reset request. It first offers the host an acknowledge byte and holds the data-ready line low while that byte is pending. Once the host has shifted the byte out, the block releases data-ready and fires a one-cycle reset pulse into the rest of the device. It then waits a fixed settling time. After that it pulls data-ready low for a startup period of one of two lengths, and finally lets the line float high again to show that reset has finished.

If the host never collects the acknowledge byte, a watchdog withdraws the byte and starts the same sequence without the host. All delays are counted in ticks of a 1 ms strobe, so a bench can shrink time by ticking faster. Data-ready is open-drain. The block only gives a pull-low enable, so "high" means released.

The state machine has four states:

- `ST_IDLE` goes to `ST_ACK` on `rst_req`.
- `ST_ACK` goes to `ST_SETTLE` on `rsp_taken`, or when the watchdog expires after `WDOG_MS` ticks.
- `ST_SETTLE` goes to `ST_STARTUP` after `SETTLE_MS` ticks.
- `ST_STARTUP` goes back to `ST_IDLE` after `SHORT_MS` or `LONG_MS` ticks.

Top module: `dev_reset_seq`

## Requirements
- R1: After `rst_n` is released, `drdy_pull_low`, `rsp_valid` and `core_rst_pulse` are all 0.
- R2: A `rst_req` seen in `ST_IDLE` makes `rsp_valid` 1 with `rsp_byte` = 0xFB, and `drdy_pull_low` 1, from the next cycle on.
- R3: A `rsp_taken` while `rsp_valid` is 1 clears `rsp_valid` and `drdy_pull_low` in the next cycle. In that same cycle `core_rst_pulse` is 1.
- R4: Exactly 20 ticks after the release of R3 (or R6), `drdy_pull_low` becomes 1.
- R5: `drdy_pull_low` then stays 1 for 4 ticks when `long_start` = 0, or 22 ticks when `long_start` = 1. `long_start` is sampled as the low phase begins. The line is then released and the block returns to idle.
- R6: If the acknowledge is not taken, then 2000 ticks after `rsp_valid` rose, `rsp_valid` clears, data-ready is released and `core_rst_pulse` fires, just as in R3.
- R7: `rst_req` has no effect outside `ST_IDLE`. `rsp_taken` has no effect while `rsp_valid` is 0.
- R8: `core_rst_pulse` is never high for two consecutive cycles, and it fires exactly once per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Confirmed reset request strobe |
| rsp_taken | input | 1 | Byte interface has shifted out the pending response |
| long_start | input | 1 | Startup low period select: 0 = short, 1 = long |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| rsp_byte | output | 8 | Acknowledge byte (0xFB) |
| rsp_valid | output | 1 | Acknowledge byte is pending |
| drdy_pull_low | output | 1 | Drive data-ready low; 0 leaves it released |
| core_rst_pulse | output | 1 | One-cycle reset to the device core |

## Verification
The bench stamps every edge of data-ready, of the response flag and of the reset pulse with the number of ticks issued so far. It compares those stamps against queued expectations, so an off-by-one in any phase counter shows up as a wrong stamp rather than passing silently.

It covers both startup lengths and the watchdog path taken with no host activity at all. It also sends stray requests and stray collect strobes during every busy phase. A design that restarted on a late request would produce extra edges. One that counted the watchdog from the wrong point would release at a shifted tick. One that held the reset pulse for two cycles is flagged by width.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK     = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_STARTUP = 2'd3
    } rseq_state_e;
endpackage

// File: rtl/rseq_ms_counter.sv
module rseq_ms_counter #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear || done)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R4/R5/R6: the phase count never reaches its own limit
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (cnt < limit));
endmodule

// File: rtl/rseq_limit_sel.sv
module rseq_limit_sel
    import rseq_pkg::*;
#(
    parameter int CW        = 11,
    parameter int SETTLE_MS = 20,
    parameter int SHORT_MS  = 4,
    parameter int LONG_MS   = 22,
    parameter int WDOG_MS   = 2000
) (
    input  rseq_state_e   state,
    input  logic          long_q,
    output logic [CW-1:0] limit
);
    always_comb begin
        unique case (state)
            ST_IDLE:    limit = CW'(1);
            ST_ACK:     limit = CW'(WDOG_MS);
            ST_SETTLE:  limit = CW'(SETTLE_MS);
            ST_STARTUP: limit = long_q ? CW'(LONG_MS) : CW'(SHORT_MS);
            default:    limit = CW'(1);
        endcase
    end
endmodule

// File: rtl/dev_reset_seq.sv
module dev_reset_seq
    import rseq_pkg::*;
#(
    parameter logic [7:0] ACK_CODE  = 8'hFB,
    parameter int         SETTLE_MS = 20,
    parameter int         SHORT_MS  = 4,
    parameter int         LONG_MS   = 22,
    parameter int         WDOG_MS   = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       rsp_taken,
    input  logic       long_start,
    input  logic       ms_tick,
    output logic [7:0] rsp_byte,
    output logic       rsp_valid,
    output logic       drdy_pull_low,
    output logic       core_rst_pulse
);
    localparam int MAX_A = (SETTLE_MS > WDOG_MS) ? SETTLE_MS : WDOG_MS;
    localparam int MAX_B = (SHORT_MS > LONG_MS) ? SHORT_MS : LONG_MS;
    localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_L + 1);

    rseq_state_e   state, state_n;
    logic          long_q;
    logic          pulse_q;
    logic          phase_done;
    logic [CW-1:0] limit;
    logic          phase_clear;

    assign phase_clear = (state_n != state);

    rseq_limit_sel #(
        .CW(CW), .SETTLE_MS(SETTLE_MS), .SHORT_MS(SHORT_MS),
        .LONG_MS(LONG_MS), .WDOG_MS(WDOG_MS)
    ) u_limit (
        .state(state), .long_q(long_q), .limit(limit)
    );

    rseq_ms_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(phase_clear),
        .tick(ms_tick), .limit(limit), .done(phase_done)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (rst_req) state_n = ST_ACK;
            ST_ACK:     if (rsp_taken || phase_done) state_n = ST_SETTLE;
            ST_SETTLE:  if (phase_done) state_n = ST_STARTUP;
            ST_STARTUP: if (phase_done) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // state register, startup-length latch, reset pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            long_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            state   <= state_n;
            pulse_q <= (state == ST_ACK) && (state_n == ST_SETTLE);
            if (state == ST_SETTLE && state_n == ST_STARTUP)
                long_q <= long_start;
        end
    end

    // outputs
    always_comb begin
        rsp_byte       = ACK_CODE;
        core_rst_pulse = pulse_q;
        unique case (state)
            ST_ACK:     begin rsp_valid = 1'b1; drdy_pull_low = 1'b1; end
            ST_STARTUP: begin rsp_valid = 1'b0; drdy_pull_low = 1'b1; end
            default:    begin rsp_valid = 1'b0; drdy_pull_low = 1'b0; end
        endcase
    end

    p_ack_holds_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> drdy_pull_low);
    p_valid_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(rst_req));
    p_pulse_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_pulse |-> (!drdy_pull_low && !rsp_valid));
    p_busy_ignores_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && rst_req) |=> !$rose(rsp_valid));
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_pulse |=> !core_rst_pulse);
endmodule

// File: tb/tb_dev_reset_seq.sv
`timescale 1ns/1ps
module tb_dev_reset_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_req = 1'b0, rsp_taken = 1'b0, long_start = 1'b0, ms_tick = 1'b0;
    logic [7:0] rsp_byte;
    logic       rsp_valid, drdy_pull_low, core_rst_pulse;

    always #10 clk = ~clk;  // 50 MHz

    dev_reset_seq dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .rsp_taken(rsp_taken),
        .long_start(long_start), .ms_tick(ms_tick), .rsp_byte(rsp_byte),
        .rsp_valid(rsp_valid), .drdy_pull_low(drdy_pull_low),
        .core_rst_pulse(core_rst_pulse)
    );

    // event codes, in the order the monitor reports them within one cycle
    localparam int EV_VRISE = 1, EV_VFALL = 2, EV_DLOW = 3, EV_DREL = 4, EV_PULSE = 5;

    int  checks = 0, errors = 0, tcount = 0, cyc = 0;
    int  exp_q[$];
    bit  mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic void push(input int code, input int stamp);
        exp_q.push_back(code * 1000000 + stamp);
    endfunction

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1; tcount++;
            @(negedge clk); ms_tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic strobe_req();
        @(negedge clk); rst_req = 1'b1;
        @(negedge clk); rst_req = 1'b0;
    endtask

    task automatic strobe_take();
        @(negedge clk); rsp_taken = 1'b1;
        @(negedge clk); rsp_taken = 1'b0;
    endtask

    // driver: expected edges of a sequence released at tick ta
    task automatic expect_tail(input int ta, input bit lng);
        push(EV_VFALL, ta); push(EV_DREL, ta); push(EV_PULSE, ta);   // R3 / R6
        push(EV_DLOW, ta + 20);                                      // R4
        push(EV_DREL, ta + 20 + (lng ? 22 : 4));                     // R5
    endtask

    // monitor: compares observed edges against the queue
    task automatic observe(input int code, input string req);
        int got = code * 1000000 + tcount;
        if (exp_q.size() == 0) begin
            chk(1'b0, req, got, 0);
        end else begin
            int e = exp_q.pop_front();
            chk(got == e, req, got, e);
        end
    endtask

    initial begin
        logic pv = 1'b0, pd = 1'b0, pp = 1'b0;
        forever begin
            @(posedge clk); #2;
            cyc++;
            if (mon_on) begin
                if (rsp_valid && !pv) begin
                    observe(EV_VRISE, "R2");
                    chk(rsp_byte == 8'hFB, "R2 byte", rsp_byte, 8'hFB);
                end
                if (!rsp_valid && pv) observe(EV_VFALL, "R3/R6");
                if (drdy_pull_low && !pd) observe(EV_DLOW, "R4");
                if (!drdy_pull_low && pd) observe(EV_DREL, "R5");
                if (core_rst_pulse) observe(EV_PULSE, "R8");
                if (core_rst_pulse && pp) chk(1'b0, "R8 width", 2, 1);
            end
            pv = rsp_valid; pd = drdy_pull_low; pp = core_rst_pulse;
        end
    end

    task automatic finish_run();
        chk(exp_q.size() == 0, "R7 leftover", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 150000);
        finish_run();
    end

    initial begin
        int ta;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(drdy_pull_low == 1'b0, "R1 drdy", drdy_pull_low, 0);
        chk(rsp_valid == 1'b0, "R1 valid", rsp_valid, 0);
        chk(core_rst_pulse == 1'b0, "R1 pulse", core_rst_pulse, 0);
        mon_on = 1'b1;

        // stray collect while idle: R7 (no edges expected)
        strobe_take();
        ticks(2);

        // sequence 1: short startup, host collects after 5 ticks
        long_start = 1'b0;
        push(EV_VRISE, tcount); push(EV_DLOW, tcount);
        strobe_req();
        ticks(3);
        strobe_req();                 // R7: ignored while acknowledge pending
        ticks(2);
        ta = tcount;
        expect_tail(ta, 1'b0);
        strobe_take();
        ticks(10);
        strobe_req();                 // R7: ignored during settle
        strobe_take();
        ticks(20);
        chk(drdy_pull_low == 1'b0, "R5 idle", drdy_pull_low, 0);

        // sequence 2: long startup
        long_start = 1'b1;
        push(EV_VRISE, tcount); push(EV_DLOW, tcount);
        strobe_req();
        ticks(1);
        ta = tcount;
        expect_tail(ta, 1'b1);
        strobe_take();
        ticks(25);
        strobe_req();                 // R7: ignored during startup
        strobe_take();
        ticks(25);
        chk(rsp_valid == 1'b0, "R5 idle", rsp_valid, 0);

        // sequence 3: host never collects, watchdog path (R6), short startup
        long_start = 1'b0;
        push(EV_VRISE, tcount); push(EV_DLOW, tcount);
        ta = tcount + 2000;
        expect_tail(ta, 1'b0);
        strobe_req();
        ticks(2030);
        chk(drdy_pull_low == 1'b0, "R6 done", drdy_pull_low, 0);

        // sequence 4: back-to-back request right after completion
        long_start = 1'b1;
        push(EV_VRISE, tcount); push(EV_DLOW, tcount);
        strobe_req();
        ta = tcount;
        expect_tail(ta, 1'b1);
        strobe_take();
        ticks(45);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule